// File: doc/BRIEF.md
# Shared Interrupt CPU-Target Register File

This block holds the CPU routing choice for every shared peripheral interrupt of an interrupt distributor serving up to eight processors. Software reaches it through a small register port with 32-bit accesses; each word packs four one-byte CPU masks, one per interrupt. The block stores a single CPU index per shared interrupt. A written mask is narrowed to its lowest set bit, so an interrupt can only ever belong to one CPU. A mask with no bits set routes the interrupt to CPU0.

From the stored indices the block drives one routing bitmap per CPU. A set bit marks an interrupt that the CPU owns. Downstream pending logic consumes these bitmaps, and a one-cycle update pulse after each accepted write tells that logic to re-evaluate. The first 32 bytes of the window cover the private interrupts. They are read-only: a read returns the requesting CPU's own bit in every byte.

Top module: `spi_target_router`

## Requirements
- R1: After reset every shared interrupt routes to CPU0. CPU0's bitmap is all ones and every other CPU's bitmap is zero. `bus_rvalid`, `bus_rdata` and `route_update` are zero.
- R2: A write to byte offset 32+4k places lane i (bits 8i+7..8i) into the target of shared interrupt 4k+i. The stored target is the index of the lowest set bit among mask bits NUM_CPUS-1..0.
- R3: A written lane whose mask bits NUM_CPUS-1..0 are all zero sets that interrupt's target to CPU0.
- R4: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. For a shared word, byte i is one-hot with bit t set, where t is the stored target of interrupt 4k+i. A read changes no target.
- R5: A read at byte offsets 0 to 31 returns the byte (1 << `bus_cpu`) repeated in all four lanes.
- R6: A write at byte offsets 0 to 31 changes no target.
- R7: Bit c*NUM_SHARED+s of `route_map` is set exactly when shared interrupt s targets CPU c, so each interrupt has exactly one owning CPU.
- R8: Lanes whose `bus_wstrb` bit is clear keep their previous targets. A write with no strobe set changes nothing.
- R9: `route_update` is high for exactly one cycle, the cycle after a write to the shared range that has at least one strobe set. It is low at every other time.
- R10: Offsets at or beyond 32+NUM_SHARED read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the target window (word aligned) |
| bus_wdata | input | 32 | Four CPU-mask lanes |
| bus_wstrb | input | 4 | Per-lane write enable |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| route_map | output | NUM_CPUS*NUM_SHARED | Per-CPU routing bitmaps, CPU c at bits c*NUM_SHARED upward |
| route_update | output | 1 | One-cycle pulse after a routing write |

## Verification
Writes are tried with four kinds of mask:
- a single bit in each lane, which tests the lane-to-interrupt mapping;
- several bits per lane, which separates lowest-bit selection from highest-bit selection or raw storage;
- all-zero lanes, which exposes a missing CPU0 default;
- partial strobes, which catch lanes written without their enable.

Every write is followed by a full comparison of the routing bitmaps and a check of the update pulse. Readback goes through a scoreboard queue. Private, shared, last-word and out-of-range offsets are each read, which separates correct address decoding from off-by-one window limits.

// File: rtl/tgt_route_pkg.sv
package tgt_route_pkg;
    localparam int LANES      = 4;
    localparam int LANE_W     = 8;
    localparam int PRIV_BYTES = 32;

    typedef struct packed {
        logic [LANES*LANE_W-1:0] rdata;
        logic                    rvalid;
        logic                    upd;
    } port_state_t;
endpackage

// File: rtl/tgt_lane_pick.sv
module tgt_lane_pick #(
    parameter int NUM_CPUS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [7:0]       lane_mask,
    output logic [IDX_W-1:0] lane_idx
);
    // Scan downward so the lowest set bit wins; an empty mask leaves CPU0.
    always_comb begin
        lane_idx = '0;
        for (int b = NUM_CPUS - 1; b >= 0; b--) begin
            if (lane_mask[b]) lane_idx = IDX_W'(b);
        end
    end
endmodule

// File: rtl/tgt_store.sv
module tgt_store #(
    parameter int NUM_SHARED = 32,
    parameter int IDX_W      = 3,
    parameter int SW_W       = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SW_W-1:0]                  wr_word,
    input  logic [3:0]                       wr_lane_en,
    input  logic [3:0][IDX_W-1:0]            wr_lane_idx,
    output logic [NUM_SHARED-1:0][IDX_W-1:0] tgt_o
);
    logic [NUM_SHARED-1:0][IDX_W-1:0] tgt_d, tgt_q;

    always_comb begin
        tgt_d = tgt_q;
        if (wr_en) begin
            for (int l = 0; l < 4; l++) begin
                if (wr_lane_en[l]) tgt_d[int'(wr_word) * 4 + l] = wr_lane_idx[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgt_q <= '0;
        else        tgt_q <= tgt_d;
    end

    assign tgt_o = tgt_q;
endmodule

// File: rtl/tgt_route_map.sv
module tgt_route_map #(
    parameter int NUM_CPUS   = 8,
    parameter int NUM_SHARED = 32,
    parameter int IDX_W      = 3
) (
    input  logic [NUM_SHARED-1:0][IDX_W-1:0] tgt_i,
    output logic [NUM_CPUS*NUM_SHARED-1:0]   map_o
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SHARED; s++) begin : g_irq
            assign map_o[c*NUM_SHARED+s] = (tgt_i[s] == IDX_W'(c));
        end
    end
endmodule

// File: rtl/spi_target_router.sv
module spi_target_router
    import tgt_route_pkg::*;
#(
    parameter int NUM_CPUS   = 8,
    parameter int NUM_SHARED = 32,
    parameter int ADDR_W     = 8,
    parameter int CPU_W      = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_valid,
    input  logic                           bus_write,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    input  logic [3:0]                     bus_wstrb,
    input  logic [CPU_W-1:0]               bus_cpu,
    output logic [31:0]                    bus_rdata,
    output logic                           bus_rvalid,
    output logic [NUM_CPUS*NUM_SHARED-1:0] route_map,
    output logic                           route_update
);
    localparam int IDX_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
    localparam int NUM_WORDS = NUM_SHARED / LANES;
    localparam int SW_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int WORD_W    = ADDR_W - 2;
    localparam int PRIV_WDS  = PRIV_BYTES / LANES;

    logic                             priv_hit, shared_hit, wr_hit;
    logic [WORD_W-1:0]                word_off;
    logic [SW_W-1:0]                  shared_word;
    logic [3:0][IDX_W-1:0]            lane_idx;
    logic [NUM_SHARED-1:0][IDX_W-1:0] tgt;
    port_state_t                      st_d, st_q;

    // Address decode
    assign word_off    = bus_addr[ADDR_W-1:2];
    assign priv_hit    = bus_addr < ADDR_W'(PRIV_BYTES);
    assign shared_hit  = !priv_hit && (bus_addr < ADDR_W'(PRIV_BYTES + NUM_SHARED));
    assign shared_word = SW_W'(word_off - WORD_W'(PRIV_WDS));
    assign wr_hit      = bus_valid && bus_write && shared_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tgt_lane_pick #(.NUM_CPUS(NUM_CPUS), .IDX_W(IDX_W)) i_pick (
            .lane_mask (bus_wdata[l*LANE_W +: LANE_W]),
            .lane_idx  (lane_idx[l])
        );
    end

    tgt_store #(.NUM_SHARED(NUM_SHARED), .IDX_W(IDX_W), .SW_W(SW_W)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_hit),
        .wr_word     (shared_word),
        .wr_lane_en  (bus_wstrb),
        .wr_lane_idx (lane_idx),
        .tgt_o       (tgt)
    );

    tgt_route_map #(.NUM_CPUS(NUM_CPUS), .NUM_SHARED(NUM_SHARED), .IDX_W(IDX_W)) i_map (
        .tgt_i (tgt),
        .map_o (route_map)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_valid && !bus_write;
        st_d.upd    = wr_hit && (|bus_wstrb);
        if (bus_valid && !bus_write) begin
            st_d.rdata = '0;
            for (int l = 0; l < LANES; l++) begin
                if (priv_hit)
                    st_d.rdata[l*LANE_W +: LANE_W] = LANE_W'(1) << bus_cpu;
                else if (shared_hit)
                    st_d.rdata[l*LANE_W +: LANE_W] =
                        LANE_W'(1) << tgt[int'(shared_word) * LANES + l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata    = st_q.rdata;
    assign bus_rvalid   = st_q.rvalid;
    assign route_update = st_q.upd;

    // R9
    upd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_update |-> $past(bus_valid && bus_write));
    // R4
    rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));
    // R6
    priv_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && priv_hit) |=> $stable(route_map));
    // R8
    no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_wstrb == 4'b0) |=> $stable(route_map));
    // R4
    read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> $stable(route_map));
    // R5
    priv_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && priv_hit) |=>
            (bus_rdata == {LANES{LANE_W'(1) << $past(bus_cpu)}}));
endmodule

// File: tb/test_spi_target_router.sv
module test_spi_target_router;
    localparam int NC = 8;
    localparam int NS = 32;
    localparam int AW = 8;
    localparam int CW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [3:0]        bus_wstrb = '0;
    logic [CW-1:0]     bus_cpu = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NC*NS-1:0]  route_map;
    logic              route_update;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int model [NS];
    logic [31:0] q_exp [$];
    string       q_tag [$];

    always #10 clk = ~clk;

    spi_target_router #(.NUM_CPUS(NC), .NUM_SHARED(NS), .ADDR_W(AW), .CPU_W(CW)) i_spi_target_router (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
        .bus_cpu(bus_cpu), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .route_map(route_map), .route_update(route_update)
    );

    task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pick_low(input logic [7:0] m);
        int r = 0;
        bit found = 1'b0;
        for (int i = 0; i < NC; i++) begin
            if (!found && m[i]) begin r = i; found = 1'b1; end
        end
        return r;
    endfunction

    function automatic logic [NC*NS-1:0] exp_map();
        logic [NC*NS-1:0] v = '0;
        for (int s = 0; s < NS; s++) v[model[s]*NS + s] = 1'b1;
        return v;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R4 unexpected read data", bus_rdata, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic do_read(input int addr, input int cpu, input string tag);
        logic [31:0] e = '0;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr); bus_cpu = CW'(cpu);
        for (int l = 0; l < 4; l++) begin
            if (addr < 32)           e[l*8 +: 8] = 8'(1) << cpu;
            else if (addr < 32 + NS) e[l*8 +: 8] = 8'(1) << model[addr - 32 + l];
        end
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic do_write(input int addr, input logic [31:0] data, input logic [3:0] strb, input string tag);
        bit hit = (addr >= 32) && (addr < 32 + NS);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(addr);
        bus_wdata = data; bus_wstrb = strb;
        if (hit) begin
            for (int l = 0; l < 4; l++)
                if (strb[l]) model[addr - 32 + l] = pick_low(data[l*8 +: 8]);
        end
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check(route_map === exp_map(), {tag, " routes"}, route_map, exp_map());
        check(route_update === (hit && (|strb)), "R9 update pulse", route_update, hit && (|strb));
        @(negedge clk);
        check(route_update === 1'b0, "R9 pulse one cycle", route_update, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) model[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(route_map === exp_map(), "R1 reset routes to CPU0", route_map, exp_map());
        check(bus_rvalid === 1'b0 && bus_rdata === '0, "R1 reset read port", bus_rdata, 0);
        check(route_update === 1'b0, "R1 reset pulse", route_update, 0);
        for (int w = 0; w < NS / 4; w++) do_read(32 + 4*w, 0, "R1 R4 reset readback");

        // R2 single bit per lane
        do_write(32, 32'h80402010, 4'hF, "R2 R7 single-bit lanes");
        do_read(32, 0, "R2 R4 readback single-bit");
        // R2 R3 multi-bit and empty lanes
        do_write(36, 32'hFF030600, 4'hF, "R2 R3 multi-bit and zero lanes");
        do_read(36, 0, "R3 R4 readback multi-bit");
        // R8 partial strobes
        do_write(32, 32'h01018080, 4'b0101, "R8 partial strobe");
        do_read(32, 0, "R8 readback partial strobe");
        do_write(36, 32'h80808080, 4'b0000, "R8 no strobe");
        do_read(36, 0, "R8 readback no strobe");
        // last shared word boundary
        do_write(32 + NS - 4, 32'h0C_30_02_40, 4'hF, "R2 last word");
        do_read(32 + NS - 4, 0, "R4 last word readback");
        // R5 R6 private window
        do_read(0, 3, "R5 private read cpu3");
        do_read(28, 7, "R5 private read cpu7");
        do_write(4, 32'h80808080, 4'hF, "R6 private write ignored");
        do_read(4, 5, "R6 R5 private readback");
        // R10 beyond window
        do_write(32 + NS, 32'h80808080, 4'hF, "R10 out-of-range write ignored");
        do_read(32 + NS, 2, "R10 out-of-range reads zero");
        do_read(32, 0, "R10 shared unchanged");

        repeat (3) @(negedge clk);
        check(q_exp.size() == 0, "R4 scoreboard drained", q_exp.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule